// File: doc/BRIEF.md
# Burst Memory Cycle Control Decoder

This block sits in front of a synchronous burst memory. On each rising clock edge it samples the chip enables, the two address strobes, the advance input and the write controls. From these it classifies the cycle as a deselect, a burst start, a burst continuation or a burst suspension. Each kind except deselect comes in a read form and a write form. For a write cycle the block also produces one strobe per byte lane.

The address generator takes its load and advance controls from this block. The data path uses the per-lane strobes, the read-valid flag and the deselect flag. Every output is registered, so it describes the cycle sampled on the edge just before. The enable state is latched whenever an address strobe is accepted. It is held through continue and suspend cycles until the next accepted strobe.

Top module: `burst_cyc_ctrl`

## Requirements
- R1: While reset is held, and before any cycle is sampled, `desel_o` is 1, `cyc_o` is 0, and all other outputs are 0.
- R2: The chip is enabled only when `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0. Two cases give a deselect cycle: an accepted strobe with the chip not enabled, and a non-strobe cycle while the latched enable is false. A deselect cycle has `cyc_o`=0 and `desel_o`=1, with the load, advance, read-valid and all write strobes at 0.
- R3: While `ce1_n_i`=1, a low `proc_as_n_i` has no effect. If `ctrl_as_n_i` is also high, the cycle is decoded as a continue or a suspend cycle.
- R4: When `proc_as_n_i`=0, `ce1_n_i`=0 and the chip is enabled, the cycle is a burst-start read (`cyc_o`=1, `load_o`=1), whatever the write controls say.
- R5: When `ctrl_as_n_i`=0, the processor strobe is not accepted and the chip is enabled, the cycle is a burst start with `load_o`=1. It is a write (`cyc_o`=2) if any lane is selected for writing, and otherwise a read (`cyc_o`=1).
- R6: `gwr_n_i`=0 selects every byte lane for writing, whatever `bwr_n_i` and `bsel_n_i` are.
- R7: With `gwr_n_i`=1 and `bwr_n_i`=0, exactly the lanes whose `bsel_n_i` bit is 0 are written. Bit i of `bsel_n_i` maps to bit i of `wr_strb_o`. Any other combination selects no lane, and the cycle is then a read.
- R8: With both strobes inactive, the latched enable true and `adv_n_i`=0, the cycle is a continue cycle with `adv_o`=1: `cyc_o`=3 for a read, 4 for a write.
- R9: With both strobes inactive, the latched enable true and `adv_n_i`=1, the cycle is a suspend cycle with `adv_o`=0 and `load_o`=0: `cyc_o`=5 for a read, 6 for a write.
- R10: `ce2_i` and `ce3_n_i` are sampled into the latched enable only on cycles where a strobe is accepted. On other cycles they have no effect.
- R11: A read cycle drives `rd_valid_o`=1 with `wr_strb_o` all 0, regardless of the byte-write controls.
- R12: The outputs change on the clock edge that samples the inputs, so they describe the cycle sampled on the edge just before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_n_i | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_n_i | input | 1 | Chip enable 3, active low |
| proc_as_n_i | input | 1 | Processor address strobe, active low |
| ctrl_as_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gwr_n_i | input | 1 | Global write, active low |
| bwr_n_i | input | 1 | Byte-write enable, active low |
| bsel_n_i | input | NB | Byte lane selects, active low |
| load_o | output | 1 | Load the address counter (burst start) |
| adv_o | output | 1 | Advance the address counter (continue) |
| wr_strb_o | output | NB | Per-lane write strobes |
| rd_valid_o | output | 1 | Read cycle, all lanes drive data |
| desel_o | output | 1 | Deselect cycle |
| cyc_o | output | 3 | Encoded cycle kind (0 to 6, see R2, R4, R5, R8, R9) |

## Verification
The assertions assume that all inputs are held stable around the rising edge and are never unknown, and that reset is applied before the first cycle. The checks that look back one cycle only start once a full sampled cycle has passed after reset. The stimulus changes inputs only on falling edges and always drives known levels. It runs directed sequences that reach each cycle kind, the strobe-masking cases and the latched-enable cases. Biased random control patterns then follow, and a behavioural model predicts every output one edge later.

// File: rtl/burst_cyc_pkg.sv
package burst_cyc_pkg;
  typedef enum logic [2:0] {
    CYC_DESEL   = 3'd0,
    CYC_BEG_RD  = 3'd1,
    CYC_BEG_WR  = 3'd2,
    CYC_CONT_RD = 3'd3,
    CYC_CONT_WR = 3'd4,
    CYC_SUSP_RD = 3'd5,
    CYC_SUSP_WR = 3'd6
  } cyc_e;
endpackage

// File: rtl/burst_ce_track.sv
module burst_ce_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic en_now_i,
  output logic en_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q_o <= 1'b0;
    else if (accept_i) en_q_o <= en_now_i;
  end
endmodule

// File: rtl/burst_wr_decode.sv
module burst_wr_decode #(
  parameter int NB = 4
) (
  input  logic          gwr_n_i,
  input  logic          bwr_n_i,
  input  logic [NB-1:0] bsel_n_i,
  output logic [NB-1:0] lanes_o,
  output logic          any_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes_o[g] = !gwr_n_i || (!bwr_n_i && !bsel_n_i[g]);
  end
  assign any_o = |lanes_o;
endmodule

// File: rtl/burst_cyc_decode.sv
module burst_cyc_decode
  import burst_cyc_pkg::*;
(
  input  logic ce1_n_i,
  input  logic ce2_i,
  input  logic ce3_n_i,
  input  logic proc_as_n_i,
  input  logic ctrl_as_n_i,
  input  logic adv_n_i,
  input  logic wr_any_i,
  input  logic en_q_i,
  output logic accept_o,
  output logic en_now_o,
  output cyc_e cyc_o
);
  logic proc_hit;

  always_comb begin
    en_now_o = !ce1_n_i && ce2_i && !ce3_n_i;
    // ce1 high masks the processor strobe
    proc_hit = !proc_as_n_i && !ce1_n_i;
    accept_o = proc_hit || !ctrl_as_n_i;
    cyc_o    = CYC_DESEL;
    if (proc_hit) begin
      if (en_now_o) cyc_o = CYC_BEG_RD;
    end else if (!ctrl_as_n_i) begin
      if (en_now_o) cyc_o = wr_any_i ? CYC_BEG_WR : CYC_BEG_RD;
    end else if (en_q_i) begin
      if (!adv_n_i) cyc_o = wr_any_i ? CYC_CONT_WR : CYC_CONT_RD;
      else          cyc_o = wr_any_i ? CYC_SUSP_WR : CYC_SUSP_RD;
    end
  end
endmodule

// File: rtl/burst_cyc_ctrl.sv
module burst_cyc_ctrl
  import burst_cyc_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce1_n_i,
  input  logic          ce2_i,
  input  logic          ce3_n_i,
  input  logic          proc_as_n_i,
  input  logic          ctrl_as_n_i,
  input  logic          adv_n_i,
  input  logic          gwr_n_i,
  input  logic          bwr_n_i,
  input  logic [NB-1:0] bsel_n_i,
  output logic          load_o,
  output logic          adv_o,
  output logic [NB-1:0] wr_strb_o,
  output logic          rd_valid_o,
  output logic          desel_o,
  output logic [2:0]    cyc_o
);
  logic [NB-1:0] lanes;
  logic          wr_any, accept, en_now, en_q;
  cyc_e          cyc_d, cyc_q;
  logic          load_d, adv_d, rd_d, wr_d;
  logic [NB-1:0] strb_q;
  logic          load_q, adv_q, rd_q, desel_q;

  burst_wr_decode #(.NB(NB)) u_wr (
    .gwr_n_i (gwr_n_i),
    .bwr_n_i (bwr_n_i),
    .bsel_n_i(bsel_n_i),
    .lanes_o (lanes),
    .any_o   (wr_any)
  );

  burst_cyc_decode u_dec (
    .ce1_n_i    (ce1_n_i),
    .ce2_i      (ce2_i),
    .ce3_n_i    (ce3_n_i),
    .proc_as_n_i(proc_as_n_i),
    .ctrl_as_n_i(ctrl_as_n_i),
    .adv_n_i    (adv_n_i),
    .wr_any_i   (wr_any),
    .en_q_i     (en_q),
    .accept_o   (accept),
    .en_now_o   (en_now),
    .cyc_o      (cyc_d)
  );

  burst_ce_track u_ce (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .en_now_i(en_now),
    .en_q_o  (en_q)
  );

  always_comb begin
    load_d = 1'b0;
    adv_d  = 1'b0;
    rd_d   = 1'b0;
    wr_d   = 1'b0;
    unique case (cyc_d)
      CYC_BEG_RD:  begin load_d = 1'b1; rd_d = 1'b1; end
      CYC_BEG_WR:  begin load_d = 1'b1; wr_d = 1'b1; end
      CYC_CONT_RD: begin adv_d  = 1'b1; rd_d = 1'b1; end
      CYC_CONT_WR: begin adv_d  = 1'b1; wr_d = 1'b1; end
      CYC_SUSP_RD: rd_d = 1'b1;
      CYC_SUSP_WR: wr_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= CYC_DESEL;
      strb_q  <= '0;
      load_q  <= 1'b0;
      adv_q   <= 1'b0;
      rd_q    <= 1'b0;
      desel_q <= 1'b1;
    end else begin
      cyc_q   <= cyc_d;
      strb_q  <= wr_d ? lanes : '0;
      load_q  <= load_d;
      adv_q   <= adv_d;
      rd_q    <= rd_d;
      desel_q <= (cyc_d == CYC_DESEL);
    end
  end

  assign cyc_o      = cyc_q;
  assign wr_strb_o  = strb_q;
  assign load_o     = load_q;
  assign adv_o      = adv_q;
  assign rd_valid_o = rd_q;
  assign desel_o    = desel_q;
endmodule

// File: rtl/burst_cyc_ctrl_chk.sv
module burst_cyc_ctrl_chk #(
  parameter int NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce1_n_i,
  input logic          ce2_i,
  input logic          ce3_n_i,
  input logic          proc_as_n_i,
  input logic          ctrl_as_n_i,
  input logic          adv_n_i,
  input logic          gwr_n_i,
  input logic          bwr_n_i,
  input logic [NB-1:0] bsel_n_i,
  input logic          load_o,
  input logic          adv_o,
  input logic [NB-1:0] wr_strb_o,
  input logic          rd_valid_o,
  input logic          desel_o
);
  logic seen_q;
  logic chip_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign chip_on = !ce1_n_i && ce2_i && !ce3_n_i;

  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel_o |-> (!rd_valid_o && !load_o && !adv_o && wr_strb_o == '0)); // R2

  AST_E1_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(ce1_n_i && ctrl_as_n_i) |-> !load_o); // R3

  AST_PROC_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(!proc_as_n_i && chip_on) |-> (load_o && rd_valid_o && wr_strb_o == '0)); // R4

  AST_GW_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(proc_as_n_i && !ctrl_as_n_i && !gwr_n_i && chip_on) |-> (&wr_strb_o)); // R6

  AST_BYTE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(proc_as_n_i && !ctrl_as_n_i && gwr_n_i && !bwr_n_i && chip_on)
      |-> (wr_strb_o == ~$past(bsel_n_i))); // R7

  AST_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past((proc_as_n_i || ce1_n_i) && ctrl_as_n_i && adv_n_i) |-> (!adv_o && !load_o)); // R9

  AST_RD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (wr_strb_o == '0)); // R11
endmodule

bind burst_cyc_ctrl burst_cyc_ctrl_chk #(.NB(NB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce1_n_i    (ce1_n_i),
  .ce2_i      (ce2_i),
  .ce3_n_i    (ce3_n_i),
  .proc_as_n_i(proc_as_n_i),
  .ctrl_as_n_i(ctrl_as_n_i),
  .adv_n_i    (adv_n_i),
  .gwr_n_i    (gwr_n_i),
  .bwr_n_i    (bwr_n_i),
  .bsel_n_i   (bsel_n_i),
  .load_o     (load_o),
  .adv_o      (adv_o),
  .wr_strb_o  (wr_strb_o),
  .rd_valid_o (rd_valid_o),
  .desel_o    (desel_o)
);

// File: tb/burst_cyc_ctrl_test.sv
module burst_cyc_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int WDOG       = 5000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce1_n, ce2, ce3_n, pas_n, cas_n, adv_n, gw_n, bw_n;
  logic [NB-1:0] bs_n;
  logic load, adv, rdv, dsl;
  logic [NB-1:0] strb;
  logic [2:0] cyc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  bit    m_en;
  int    e_cyc, e_strb, e_load, e_adv, e_rd, e_dsl;
  string e_rule;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_cyc_ctrl #(.NB(NB)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_n_i(ce3_n),
    .proc_as_n_i(pas_n), .ctrl_as_n_i(cas_n), .adv_n_i(adv_n),
    .gwr_n_i(gw_n), .bwr_n_i(bw_n), .bsel_n_i(bs_n),
    .load_o(load), .adv_o(adv), .wr_strb_o(strb),
    .rd_valid_o(rdv), .desel_o(dsl), .cyc_o(cyc)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // R12: outputs sampled here reflect inputs applied one edge earlier
  task automatic compare();
    chk(e_rule, "cyc", int'(cyc), e_cyc);
    chk(e_rule, "wr_strb", int'(strb), e_strb);
    chk("R12", "load", int'(load), e_load);
    chk("R12", "adv", int'(adv), e_adv);
    chk("R11", "rd_valid", int'(rdv), e_rd);
    chk("R2", "desel", int'(dsl), e_dsl);
  endtask

  task automatic predict();
    bit en_now, phit, wr;
    int lanes;
    en_now = !ce1_n && ce2 && !ce3_n;
    phit   = !pas_n && !ce1_n;
    lanes  = !gw_n ? ((1 << NB) - 1) : (!bw_n ? int'(~bs_n) & ((1 << NB) - 1) : 0);
    wr     = (lanes != 0);
    e_cyc = 0; e_rule = "R2";
    if (phit) begin
      if (en_now) begin e_cyc = 1; e_rule = "R4"; end
      m_en = en_now;
    end else if (!cas_n) begin
      if (en_now) begin
        e_cyc  = wr ? 2 : 1;
        e_rule = !gw_n ? "R6" : (!bw_n ? "R7" : "R5");
      end
      m_en = en_now;
    end else if (!m_en) begin
      e_rule = "R10";
    end else begin
      if (!adv_n) begin e_cyc = wr ? 4 : 3; e_rule = "R8"; end
      else        begin e_cyc = wr ? 6 : 5; e_rule = "R9"; end
      if (!pas_n) e_rule = "R3";
    end
    e_dsl  = (e_cyc == 0);
    e_load = (e_cyc == 1 || e_cyc == 2);
    e_adv  = (e_cyc == 3 || e_cyc == 4);
    e_rd   = (e_cyc == 1 || e_cyc == 3 || e_cyc == 5);
    e_strb = (e_cyc == 2 || e_cyc == 4 || e_cyc == 6) ? lanes : 0;
  endtask

  task automatic step(bit e1n, bit e2, bit e3n, bit pn, bit cn, bit avn,
                      bit gwn, bit bwn, logic [NB-1:0] bsn);
    @(negedge clk);
    compare();
    ce1_n = e1n; ce2 = e2; ce3_n = e3n; pas_n = pn; cas_n = cn;
    adv_n = avn; gw_n = gwn; bw_n = bwn; bs_n = bsn;
    predict();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    ce1_n = 1; ce2 = 0; ce3_n = 1; pas_n = 1; cas_n = 1; adv_n = 1;
    gw_n = 1; bw_n = 1; bs_n = '1;
    m_en = 0;
    e_cyc = 0; e_strb = 0; e_load = 0; e_adv = 0; e_rd = 0; e_dsl = 1; e_rule = "R1";
    repeat (3) @(negedge clk);
    compare(); // R1 while reset held
    rst_ni = 1'b1;
    // R2: controller strobe with enable 2 low -> deselect
    step(0, 0, 0, 1, 0, 1, 1, 1, 4'hF);
    // R4: processor strobe start is a read even with global write low
    step(0, 1, 0, 0, 1, 1, 0, 0, 4'h0);
    // R8, R10: continue reads with enable 2/3 dropped (ignored)
    step(0, 0, 1, 1, 1, 0, 1, 1, 4'hF);
    step(0, 0, 0, 1, 1, 0, 1, 0, 4'hF);
    // R9, R11: suspend read with byte-write enable low but no lane
    step(0, 1, 0, 1, 1, 1, 1, 0, 4'hF);
    // R5, R6: controller strobe write, global write
    step(0, 1, 0, 1, 0, 1, 0, 1, 4'hF);
    // R7, R8: continue write, lanes 0 and 2
    step(0, 1, 0, 1, 1, 0, 1, 0, 4'b1010);
    // R9: suspend write, lane 3 only
    step(0, 1, 0, 1, 1, 1, 1, 0, 4'b0111);
    // R3: processor strobe masked by ce1 high -> continue
    step(1, 1, 0, 0, 1, 0, 1, 1, 4'hF);
    // R7: byte-write enable low, no lane selected -> begin read
    step(0, 1, 0, 1, 0, 1, 1, 0, 4'hF);
    // R2: controller strobe with enable 3 high -> deselect
    step(0, 1, 1, 1, 0, 0, 1, 1, 4'hF);
    // R10: latched enable false, continue attempt stays deselected
    step(0, 1, 0, 1, 1, 0, 0, 1, 4'hF);
    // R2: processor strobe with ce1 low but enable 2 low -> deselect
    step(0, 0, 0, 0, 0, 0, 0, 1, 4'hF);
    for (int i = 0; i < 400; i++) begin
      step($urandom % 4 == 0, $urandom % 5 != 0, $urandom % 5 == 0,
           $urandom % 3 != 0, $urandom % 3 != 0, $urandom % 2 == 0,
           $urandom % 4 != 0, $urandom % 2 == 0, 4'($urandom));
    end
    step(1, 0, 1, 1, 1, 1, 1, 1, 4'hF);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule